// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This peripheral lets a host processor talk to SPI slave devices through six 32-bit registers on a simple word bus. Each write to the transmit register starts one full-duplex exchange of eight bits. The block drives SCK, MOSI and one of up to eight active-low chip selects, and samples MISO. When the exchange ends, the received byte can be read from the receive register. A ready flag in the control register is set at the same time, together with a status bit that can be routed to an interrupt line.

The SCK rate comes from a prescaler. Its divide ratio is a 4-bit linear factor multiplied by a power of two. The 3-bit exponent is split across two separate places in the configuration register. The clock polarity and phase are chosen as one of the four usual SPI modes. The chip-select number and the chip-select enable are separate fields, so software can pick a device first and assert it afterwards.

Top module: `spim_top`

## Requirements
- R1: After reset, every register reads zero, all `cs_n` lines are high, `irq` is low, and `sck` and `mosi` are low.
- R2: The SCK period is D = max(S,2) × 2^E system clocks. S is configuration bits 3:0. E is a 3-bit exponent: its bit 0 is configuration bit 4 and its bits 2:1 are configuration bits 7:6. The first half of each bit period lasts floor(D/2) clocks and the second half takes the rest.
- R3: Configuration bit 13 is clock polarity and bit 12 is clock phase (mode = 2×bit13 + bit12). While idle, SCK sits at the polarity level. During the first half of each bit period, SCK equals polarity XOR phase, and during the second half it equals the inverse of that.
- R4: A write to offset 0x8 while idle starts an 8-bit exchange of wdata[7:0], most significant bit first. MOSI carries the current bit for a whole bit period and is low when idle. MISO is sampled at the half-period SCK transition. The assembled byte reads at offset 0xC in bits 7:0, with bits 31:8 reading zero.
- R5: Control bit 1 (ready) is set on the clock edge that ends an exchange. It is cleared by an accepted transmit write. Control-register writes leave it unchanged.
- R6: A transmit write that arrives during an exchange is ignored. The MOSI stream and the received byte of the running exchange are unaffected, and no new exchange follows.
- R7: Status bit 0 at offset 0x10 is set when an exchange ends. A write to 0x10 with wdata[0]=0 clears it, a write with wdata[0]=1 leaves it unchanged, and completion wins over a clear in the same cycle.
- R8: `irq` is high exactly when status bit 0 and mask bit 0 (offset 0x14) are both set.
- R9: Control bits 4:2 select a chip-select number and control bit 0 asserts it. `cs_n[n]` is low only when bit 0 is set and the number equals n. All other lines stay high.
- R10: Configuration reads back bits 13:12 and 7:0 as written, other bits as zero. Bit 5 is stored and readable but each exchange is still 8 bits. Control reads back bits 4:2 and 0 as written, bit 1 as the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong prescaler count or a misdecoded exponent bit appears on `sck` within the first half-period of an exchange. A swapped polarity or phase is visible from the first clock after the write. A bit counter that is off by one stretches or shortens the exchange by a full SCK period, which moves the fall of busy, the ready flag and `irq` by D clocks. A wrong shift direction gives a wrong MOSI level on the first bit. Because the bench compares `sck`, `mosi`, `cs_n` and `irq` with a behavioural model on every clock, such faults are reported at the first cycle they appear rather than at the end of the exchange.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W   = 8;
  localparam int SPR_W    = 4;
  localparam int EXP_W    = 3;
  localparam int DIV_W    = SPR_W + (1 << EXP_W) - 1;
  localparam int BITCNT_W = $clog2(DATA_W);
  localparam int CSIDX_W  = 3;
  localparam int ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_CONF = 5'h04;
  localparam logic [ADDR_W-1:0] A_TX   = 5'h08;
  localparam logic [ADDR_W-1:0] A_RX   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_IST  = 5'h10;
  localparam logic [ADDR_W-1:0] A_IMSK = 5'h14;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic [SPR_W-1:0] lin_fac,
  input  logic [EXP_W-1:0] pow_exp,
  output logic [DIV_W-1:0] div_ratio
);
  logic [SPR_W-1:0] lin_eff;

  // Factors below two are promoted to two so a period never collapses.
  always_comb begin
    lin_eff   = (lin_fac < SPR_W'(2)) ? SPR_W'(2) : lin_fac;
    div_ratio = DIV_W'(lin_eff) << pow_exp;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck,
  output logic              mosi
);
  logic                busy_q, busy_d;
  logic [DIV_W-1:0]    cnt_q, cnt_d;
  logic [DIV_W-1:0]    div_q, div_d;
  logic [DIV_W-1:0]    half_q, half_d;
  logic [BITCNT_W-1:0] bit_q, bit_d;
  logic [DATA_W-1:0]   sh_q, sh_d;
  logic [DATA_W-1:0]   rx_q, rx_d;
  logic                samp_q, samp_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    half_d = half_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    samp_d = samp_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == half_q - DIV_W'(1)) samp_d = miso;
      if (cnt_q == div_q - DIV_W'(1)) begin
        cnt_d = '0;
        sh_d  = {sh_q[DATA_W-2:0], samp_q};
        if (bit_q == BITCNT_W'(DATA_W - 1)) begin
          busy_d = 1'b0;
          done   = 1'b1;
          rx_d   = {sh_q[DATA_W-2:0], samp_q};
        end else begin
          bit_d = bit_q + BITCNT_W'(1);
        end
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      bit_d  = '0;
      sh_d   = tx_byte;
      div_d  = div_ratio;
      half_d = div_ratio >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      half_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      samp_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      samp_q <= samp_d;
    end
  end

  assign busy    = busy_q;
  assign rx_byte = rx_q;
  assign mosi    = busy_q & sh_q[DATA_W-1];
  assign sck     = busy_q ? (cpol ^ cpha ^ (cnt_q >= half_q)) : cpol;

  // R6: the register file must never launch an exchange over a running one
  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R2: a latched period shorter than two clocks would lose an SCK half
  p_div_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (div_q >= DIV_W'(2)));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_CS-1:0]  cs_n,
  output logic               irq
);
  logic rst_meta_q, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  logic               cs_en_q, cs_en_d;
  logic [CSIDX_W-1:0] cs_idx_q, cs_idx_d;
  logic               ready_q, ready_d;
  logic [1:0]         mode_q, mode_d;
  logic [7:0]         cfg_lo_q, cfg_lo_d;
  logic               ist_q, ist_d;
  logic               imsk_q, imsk_d;
  logic               start, busy, done;
  logic [DATA_W-1:0]  rx_byte;
  logic [DIV_W-1:0]   div_ratio;

  assign start = bus_wr && (bus_addr == A_TX) && !busy;

  always_comb begin
    cs_en_d  = cs_en_q;
    cs_idx_d = cs_idx_q;
    ready_d  = ready_q;
    mode_d   = mode_q;
    cfg_lo_d = cfg_lo_q;
    ist_d    = ist_q;
    imsk_d   = imsk_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          cs_en_d  = bus_wdata[0];
          cs_idx_d = bus_wdata[4:2];
        end
        A_CONF: begin
          mode_d   = bus_wdata[13:12];
          cfg_lo_d = bus_wdata[7:0];
        end
        A_IST:  if (!bus_wdata[0]) ist_d = 1'b0;
        A_IMSK: imsk_d = bus_wdata[0];
        default: ;
      endcase
    end
    if (start) ready_d = 1'b0;
    if (done) begin
      ready_d = 1'b1;
      ist_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cs_en_q  <= 1'b0;
      cs_idx_q <= '0;
      ready_q  <= 1'b0;
      mode_q   <= '0;
      cfg_lo_q <= '0;
      ist_q    <= 1'b0;
      imsk_q   <= 1'b0;
    end else begin
      cs_en_q  <= cs_en_d;
      cs_idx_q <= cs_idx_d;
      ready_q  <= ready_d;
      mode_q   <= mode_d;
      cfg_lo_q <= cfg_lo_d;
      ist_q    <= ist_d;
      imsk_q   <= imsk_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {27'd0, cs_idx_q, ready_q, cs_en_q};
      A_CONF: bus_rdata = {18'd0, mode_q, 4'd0, cfg_lo_q};
      A_RX:   bus_rdata = {{(32-DATA_W){1'b0}}, rx_byte};
      A_IST:  bus_rdata = {31'd0, ist_q};
      A_IMSK: bus_rdata = {31'd0, imsk_q};
      default: bus_rdata = '0;
    endcase
  end

  spim_clkdiv u_div (
    .lin_fac   (cfg_lo_q[3:0]),
    .pow_exp   ({cfg_lo_q[7:6], cfg_lo_q[4]}),
    .div_ratio (div_ratio)
  );

  spim_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .tx_byte   (bus_wdata[DATA_W-1:0]),
    .cpol      (mode_q[1]),
    .cpha      (mode_q[0]),
    .div_ratio (div_ratio),
    .miso      (miso),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .sck       (sck),
    .mosi      (mosi)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_en_q && (cs_idx_q == CSIDX_W'(g)));
  end

  assign irq = ist_q & imsk_q;

  // R5: the flag follows the engine's completion one edge later
  p_ready_after_done_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> ready_q);
  // R5: only an accepted transmit write takes the flag down
  p_ready_fall_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ready_q) |-> $past(start));
  // R7: status rises only as a consequence of a finished exchange
  p_ist_cause_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ist_q) |-> $past(done));
endmodule

// File: tb/spim_top_bench.sv
module spim_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  always #4 clk = ~clk;

  spim_top u_spim_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // behavioural reference state
  bit m_busy, m_ready, m_ist, m_msk, m_en, m_pol, m_pha, m_samp;
  int m_idx, m_spr, m_exp, m_cnt, m_bit, m_D, m_H;
  bit [7:0] m_sh, m_rx, pat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_ist = 0; m_msk = 0; m_en = 0;
      m_pol = 0; m_pha = 0; m_idx = 0; m_spr = 0; m_exp = 0;
      m_cnt = 0; m_bit = 0; m_D = 2; m_H = 1; m_sh = 0; m_rx = 0; m_samp = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: begin m_en = bus_wdata[0]; m_idx = bus_wdata[4:2]; end
          5'h04: begin
            m_pol = bus_wdata[13]; m_pha = bus_wdata[12];
            m_spr = bus_wdata[3:0];
            m_exp = {bus_wdata[7:6], bus_wdata[4]};
          end
          5'h08: if (!was_busy) begin
            m_busy = 1; m_cnt = 0; m_bit = 0; m_sh = bus_wdata[7:0];
            m_D = ((m_spr < 2) ? 2 : m_spr) * (1 << m_exp);
            m_H = m_D / 2; m_ready = 0;
          end
          5'h10: if (!bus_wdata[0]) m_ist = 0;
          5'h14: m_msk = bus_wdata[0];
          default: ;
        endcase
      end
      if (was_busy) begin
        if (m_cnt == m_H - 1) m_samp = miso;
        if (m_cnt == m_D - 1) begin
          m_sh = {m_sh[6:0], m_samp};
          m_cnt = 0;
          if (m_bit == 7) begin
            m_busy = 0; m_rx = m_sh; m_ready = 1; m_ist = 1;
          end else m_bit++;
        end else m_cnt++;
      end
    end
  end

  task automatic cmp1(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  // per-clock comparison and MISO stimulus, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      bit [7:0] exp_cs;
      exp_cs = 8'hFF;
      if (m_en) exp_cs[m_idx] = 1'b0;
      cmp1("R2/R3", "sck", sck, m_busy ? (m_pol ^ m_pha ^ (m_cnt >= m_H)) : m_pol);
      cmp1("R4", "mosi", mosi, m_busy & m_sh[7]);
      cmp1("R8", "irq", irq, m_ist & m_msk);
      vectors++;
      if (cs_n !== exp_cs) begin
        errors++;
        $display("FAIL R9 cs_n: actual %h expected %h", cs_n, exp_cs);
      end
    end
    miso = m_busy ? pat[7 - m_bit] : 1'b0;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] conf, input logic [7:0] tx, input logic [7:0] slave);
    wr(5'h04, conf);
    pat = slave;
    wr(5'h08, {24'hABCDEF, tx});
    wait_idle();
    rd(5'h0C, {24'd0, slave}, "R4 received byte");
    rd(5'h10, 32'd1, "R7 status set");
  endtask

  initial begin
    pat = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) rd(5'(a * 4), 32'd0, "R1 reset value");

    // R9 chip select number 3, asserted
    wr(5'h00, 32'h0000_000D);
    rd(5'h00, 32'h0000_000D, "R10 ctrl readback");
    // mode 0, D=2
    xfer(32'h0000_0002, 8'hA5, 8'h3C);
    rd(5'h00, 32'h0000_000F, "R5 ready set");
    rd(5'h04, 32'h0000_0002, "R10 conf readback");

    // R7 write of 1 keeps status, write of 0 clears
    wr(5'h10, 32'h1);
    rd(5'h10, 32'd1, "R7 write one no effect");
    wr(5'h10, 32'h0);
    rd(5'h10, 32'd0, "R7 write zero clears");

    // R8 mask on; R10 mode 3 with two-byte bit, D=6
    wr(5'h14, 32'h1);
    wr(5'h00, 32'h0000_001D);
    wr(5'h04, 32'h0000_3033);
    rd(5'h04, 32'h0000_3033, "R10 two-byte bit stored");
    pat = 8'hC3;
    wr(5'h08, 32'h0000_005A);
    rd(5'h00, 32'h0000_001D, "R5 ready cleared by transmit");
    // R6 transmit during exchange ignored
    repeat (5) @(negedge clk);
    wr(5'h08, 32'h0000_00FF);
    wait_idle();
    rd(5'h0C, 32'h0000_00C3, "R6 received byte unaffected");
    rd(5'h00, 32'h0000_001F, "R5 ready after exchange");
    repeat (20) @(negedge clk);   // no second exchange may start (R6)
    wr(5'h10, 32'h0);

    // R3 mode 1 with exponent split bits, D=64, factor 0 promoted (R2)
    wr(5'h00, 32'h0000_0001);
    xfer(32'h0000_1090, 8'h81, 8'h7E);
    // odd divider D=3, mode 0
    wr(5'h00, 32'h0000_0019);
    xfer(32'h0000_0003, 8'h0F, 8'hF0);
    // mode 2, largest divider D=1920
    xfer(32'h0000_20DF, 8'h6B, 8'h94);

    // R10 unused bits read zero
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, 32'h0000_30FF, "R10 conf mask");
    wr(5'h00, 32'h0000_0000);
    rd(5'h08, 32'd0, "R10 transmit reads zero");
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule